// File: doc/BRIEF.md
# PCM Highway Receive Time-Slot Framer

This block sits on the receive side of a serial PCM highway. On every rising edge of the receive clock it samples one data bit. A rising edge on the sync input marks the bit sampled on that edge as the first bit of a new frame. From that point the block counts bit positions through the frame and works out which time slot each bit belongs to, and which bit of that slot it is.

A small configuration table holds three things for each table entry: an 8-bit fill mask, a logical channel number and an enable. Each bit that falls in an enabled slot, and whose mask bit is set, comes out as a single-cycle strobe. The strobe carries the data bit, the channel number and the highway slot index. A downstream deframer collects the strobes for each channel.

Four frame layouts are supported:
- 32 slots of 8 bits.
- 24 slots preceded by one framing bit, which is dropped.
- 24 slots with no framing bit.
- 64 slots, of which only the even-numbered or only the odd-numbered slots are handled.

The receive timing depends only on the receive clock and the sync input.

Top module: `pcmRxFramer`

## Requirements
- R1: A rising edge of `rxSync`, sampled on a clock edge, makes the bit sampled on that same edge frame position 0. Each strobe appears on the outputs one clock after its bit is sampled. No strobe is produced before the first sync edge after reset.
- R2: With `fmtSel`=0 the frame is 256 bits long. A bit at position p belongs to slot p/8, and is bit p%8 of that slot counted from the MSB, which is received first.
- R3: With `fmtSel`=2 the frame is 192 bits long and holds slots 0..23, with the same bit layout as R2.
- R4: With `fmtSel`=1 the frame is 193 bits long. Position 0 is a framing bit that never produces a strobe. Slot 0 starts at position 1, so a bit at position p belongs to slot (p-1)/8.
- R5: With `fmtSel`=3 the frame is 512 bits long and holds 64 slots. Only slots whose index LSB equals `oddSel` are handled, and highway slot s uses table entry s/2.
- R6: Mask bit 7 governs the first bit received in a slot and mask bit 0 governs the last. A bit whose mask bit is 0 produces no strobe.
- R7: `bitChan` carries the channel number of the table entry for the slot. Several entries may hold the same channel number.
- R8: A slot whose table entry has its enable cleared produces no strobe.
- R9: A sync edge at any position other than 0, while the block is already aligned, restarts counting at position 0. It also raises `syncErr` for exactly one cycle, in the same cycle as that bit's output. A sync edge at position 0 raises no error.
- R10: Reset clears all outputs. While `bitValid` is 0, the outputs `bitData`, `bitChan` and `bitSlot` are 0.
- R11: A write with `cfgWe` high updates the mask, channel and enable of entry `cfgAddr` on that clock edge. The bit sampled on the same edge still uses the old entry, and bits sampled after it use the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rxClk | input | 1 | Receive bit clock; data sampled on rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 1 | Serial receive data |
| rxSync | input | 1 | Frame sync; rising edge marks position 0 |
| fmtSel | input | 2 | Frame layout: 0 = 32 slots, 1 = 24 slots plus framing bit, 2 = 24 slots, 3 = 64 slots |
| oddSel | input | 1 | In 64-slot layout: 1 handles odd slots, 0 handles even slots |
| cfgWe | input | 1 | Table write enable |
| cfgAddr | input | 5 | Table entry to write |
| cfgMask | input | 8 | Fill mask to write |
| cfgChan | input | CHAN_W | Channel number to write |
| cfgEn | input | 1 | Entry enable to write |
| bitValid | output | 1 | Strobe for one accepted bit |
| bitData | output | 1 | Accepted data bit |
| bitChan | output | CHAN_W | Channel of the accepted bit |
| bitSlot | output | 6 | Highway slot index of the accepted bit |
| syncErr | output | 1 | One-cycle pulse on misplaced sync |

## Verification
Two things can land in the same cycle.

The first is a misplaced sync edge and an accepted bit. The bench sends a sync pulse in the middle of a slot whose entry is enabled. It then expects `syncErr` together with a strobe for slot 0 in the following cycle, and it expects no error one full frame later.

The second is a table write and a bit that looks up the entry being written. The bench rewrites table entries while data keeps streaming. Its model applies each write only after it has computed the expected output for the bit sampled on that same edge, so any mix-up of old and new table contents shows up as a mismatch.

// File: rtl/pcmRxPkg.sv
package pcmRxPkg;
  localparam int SLOT_BITS = 8;
  localparam int BIT_W     = $clog2(SLOT_BITS);
  localparam int MAX_SLOTS = 64;
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
  localparam int TAB_DEPTH = 32;
  localparam int TAB_AW    = $clog2(TAB_DEPTH);
  localparam int POS_W     = $clog2(MAX_SLOTS * SLOT_BITS);

  typedef enum logic [1:0] {
    FMT_SLOT32  = 2'd0,
    FMT_SLOT24F = 2'd1,
    FMT_SLOT24  = 2'd2,
    FMT_SLOT64  = 2'd3
  } fmtE;

  typedef struct packed {
    logic              sample;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitIdx;
    logic [TAB_AW-1:0] tabIdx;
    logic              syncErr;
  } ctrlStrobeT;
endpackage

// File: rtl/pcmRxCtrl.sv
module pcmRxCtrl
  import pcmRxPkg::*;
(
  input  logic       rxClk,
  input  logic       rstN,
  input  logic       rxSync,
  input  fmtE        fmt,
  input  logic       oddSel,
  output ctrlStrobeT strobe
);
  localparam logic [POS_W:0] LEN32  = (POS_W+1)'(32 * SLOT_BITS);
  localparam logic [POS_W:0] LEN24  = (POS_W+1)'(24 * SLOT_BITS);
  localparam logic [POS_W:0] LEN24F = (POS_W+1)'(24 * SLOT_BITS + 1);
  localparam logic [POS_W:0] LEN64  = (POS_W+1)'(64 * SLOT_BITS);

  logic             syncPrev;
  logic             locked;
  logic [POS_W-1:0] posReg;

  logic             syncEdge;
  logic             active;
  logic [POS_W-1:0] curPos;
  logic [POS_W-1:0] dataPos;
  logic [POS_W:0]   frameLen;
  logic             isFbit;
  logic             handled;
  logic [SLOT_W-1:0] slot;
  logic [POS_W-1:0] nextPos;

  always_comb begin
    syncEdge = rxSync & ~syncPrev;
    active   = locked | syncEdge;
    curPos   = syncEdge ? '0 : posReg;

    unique case (fmt)
      FMT_SLOT32:  frameLen = LEN32;
      FMT_SLOT24F: frameLen = LEN24F;
      FMT_SLOT24:  frameLen = LEN24;
      default:     frameLen = LEN64;
    endcase

    isFbit  = (fmt == FMT_SLOT24F) && (curPos == '0);
    dataPos = (fmt == FMT_SLOT24F) ? curPos - POS_W'(1) : curPos;
    slot    = dataPos[POS_W-1:BIT_W];
    handled = (fmt != FMT_SLOT64) || (slot[0] == oddSel);

    strobe.sample  = active & ~isFbit & handled;
    strobe.slot    = slot;
    strobe.bitIdx  = dataPos[BIT_W-1:0];
    strobe.tabIdx  = (fmt == FMT_SLOT64) ? slot[SLOT_W-1:1] : slot[TAB_AW-1:0];
    strobe.syncErr = syncEdge & locked & (posReg != '0);

    nextPos = ({1'b0, curPos} >= frameLen - (POS_W+1)'(1)) ? '0 : curPos + POS_W'(1);
  end

  always_ff @(posedge rxClk) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      locked   <= 1'b0;
      posReg   <= '0;
    end else begin
      syncPrev <= rxSync;
      if (syncEdge) locked <= 1'b1;
      if (active) posReg <= nextPos;
    end
  end
endmodule

// File: rtl/pcmRxDatapath.sv
module pcmRxDatapath
  import pcmRxPkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic                 rxClk,
  input  logic                 rstN,
  input  logic                 rxData,
  input  ctrlStrobeT           strobe,
  input  logic                 cfgWe,
  input  logic [TAB_AW-1:0]    cfgAddr,
  input  logic [SLOT_BITS-1:0] cfgMask,
  input  logic [CHAN_W-1:0]    cfgChan,
  input  logic                 cfgEn,
  output logic                 bitValid,
  output logic                 bitData,
  output logic [CHAN_W-1:0]    bitChan,
  output logic [SLOT_W-1:0]    bitSlot,
  output logic                 syncErr
);
  logic [SLOT_BITS-1:0] maskTab [TAB_DEPTH];
  logic [CHAN_W-1:0]    chanTab [TAB_DEPTH];
  logic [TAB_DEPTH-1:0] enTab;

  for (genvar g = 0; g < TAB_DEPTH; g++) begin : gEntry
    always_ff @(posedge rxClk) begin
      if (!rstN) begin
        maskTab[g] <= '1;
        chanTab[g] <= '0;
        enTab[g]   <= 1'b0;
      end else if (cfgWe && (cfgAddr == TAB_AW'(g))) begin
        maskTab[g] <= cfgMask;
        chanTab[g] <= cfgChan;
        enTab[g]   <= cfgEn;
      end
    end
  end

  logic [SLOT_BITS-1:0] selMask;
  logic [BIT_W-1:0]     maskPos;
  logic                 hit;

  always_comb begin
    selMask = maskTab[strobe.tabIdx];
    maskPos = BIT_W'(SLOT_BITS - 1) - strobe.bitIdx;
    hit     = strobe.sample & enTab[strobe.tabIdx] & selMask[maskPos];
  end

  always_ff @(posedge rxClk) begin
    if (!rstN) begin
      bitValid <= 1'b0;
      bitData  <= 1'b0;
      bitChan  <= '0;
      bitSlot  <= '0;
      syncErr  <= 1'b0;
    end else begin
      bitValid <= hit;
      bitData  <= hit & rxData;
      bitChan  <= hit ? chanTab[strobe.tabIdx] : '0;
      bitSlot  <= hit ? strobe.slot : '0;
      syncErr  <= strobe.syncErr;
    end
  end
endmodule

// File: rtl/pcmRxFramer.sv
module pcmRxFramer
  import pcmRxPkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic                 rxClk,
  input  logic                 rstN,
  input  logic                 rxData,
  input  logic                 rxSync,
  input  logic [1:0]           fmtSel,
  input  logic                 oddSel,
  input  logic                 cfgWe,
  input  logic [TAB_AW-1:0]    cfgAddr,
  input  logic [SLOT_BITS-1:0] cfgMask,
  input  logic [CHAN_W-1:0]    cfgChan,
  input  logic                 cfgEn,
  output logic                 bitValid,
  output logic                 bitData,
  output logic [CHAN_W-1:0]    bitChan,
  output logic [SLOT_W-1:0]    bitSlot,
  output logic                 syncErr
);
  ctrlStrobeT strobe;

  pcmRxCtrl u_ctrl (
    .rxClk  (rxClk),
    .rstN   (rstN),
    .rxSync (rxSync),
    .fmt    (fmtE'(fmtSel)),
    .oddSel (oddSel),
    .strobe (strobe)
  );

  pcmRxDatapath #(.CHAN_W(CHAN_W)) u_dp (
    .rxClk    (rxClk),
    .rstN     (rstN),
    .rxData   (rxData),
    .strobe   (strobe),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgMask  (cfgMask),
    .cfgChan  (cfgChan),
    .cfgEn    (cfgEn),
    .bitValid (bitValid),
    .bitData  (bitData),
    .bitChan  (bitChan),
    .bitSlot  (bitSlot),
    .syncErr  (syncErr)
  );
endmodule

// File: rtl/pcmRxFramerChk.sv
module pcmRxFramerChk
  import pcmRxPkg::*;
#(
  parameter int CHAN_W = 5
) (
  input logic              rxClk,
  input logic              rstN,
  input logic [1:0]        fmtSel,
  input logic              oddSel,
  input logic              bitValid,
  input logic              bitData,
  input logic [CHAN_W-1:0] bitChan,
  input logic [SLOT_W-1:0] bitSlot,
  input logic              syncErr
);
  assert_slot32_range_R2: assert property (@(posedge rxClk) disable iff (!rstN)
    bitValid && ($past(fmtSel) == 2'd0) |-> bitSlot < SLOT_W'(32));

  assert_slot24_range_R3: assert property (@(posedge rxClk) disable iff (!rstN)
    bitValid && ($past(fmtSel) == 2'd2) |-> bitSlot < SLOT_W'(24));

  assert_fbit_range_R4: assert property (@(posedge rxClk) disable iff (!rstN)
    bitValid && ($past(fmtSel) == 2'd1) |-> bitSlot < SLOT_W'(24));

  assert_slot_parity_R5: assert property (@(posedge rxClk) disable iff (!rstN)
    bitValid && ($past(fmtSel) == 2'd3) |-> bitSlot[0] == $past(oddSel));

  assert_sync_err_pulse_R9: assert property (@(posedge rxClk) disable iff (!rstN)
    syncErr |=> !syncErr);

  assert_idle_outputs_R10: assert property (@(posedge rxClk) disable iff (!rstN)
    !bitValid |-> (bitChan == '0) && (bitSlot == '0) && !bitData);
endmodule

bind pcmRxFramer pcmRxFramerChk #(.CHAN_W(CHAN_W)) u_chk (
  .rxClk    (rxClk),
  .rstN     (rstN),
  .fmtSel   (fmtSel),
  .oddSel   (oddSel),
  .bitValid (bitValid),
  .bitData  (bitData),
  .bitChan  (bitChan),
  .bitSlot  (bitSlot),
  .syncErr  (syncErr)
);

// File: tb/test_pcmRxFramer.sv
module test_pcmRxFramer;
  logic rxClk = 1'b0;
  always #5 rxClk = ~rxClk;

  logic       rstN, rxData, rxSync, oddSel, cfgWe, cfgEn;
  logic [1:0] fmtSel;
  logic [4:0] cfgAddr, cfgChan;
  logic [7:0] cfgMask;
  logic       bitValid, bitData, syncErr;
  logic [4:0] bitChan;
  logic [5:0] bitSlot;

  pcmRxFramer #(.CHAN_W(5)) i_pcmRxFramer (
    .rxClk(rxClk), .rstN(rstN), .rxData(rxData), .rxSync(rxSync),
    .fmtSel(fmtSel), .oddSel(oddSel), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgMask(cfgMask), .cfgChan(cfgChan), .cfgEn(cfgEn),
    .bitValid(bitValid), .bitData(bitData), .bitChan(bitChan),
    .bitSlot(bitSlot), .syncErr(syncErr)
  );

  int total = 0;
  int bad   = 0;

  logic [7:0] mMask [32];
  logic [4:0] mChan [32];
  logic       mEn   [32];
  logic       mPrev   = 1'b0;
  logic       mLocked = 1'b0;
  int         mPos    = 0;

  function automatic int frameLen(input logic [1:0] f);
    case (f)
      2'd0: return 256;
      2'd1: return 193;
      2'd2: return 192;
      default: return 512;
    endcase
  endfunction

  task automatic step(input logic d, input logic s, input string tag);
    logic expV, expD, expE, edgeSeen, fbit, handled;
    logic [4:0] expC;
    logic [5:0] expS;
    int cur, dp, slot, b, idx;
    @(negedge rxClk);
    rxData = d;
    rxSync = s;
    expV = 0; expD = 0; expC = 0; expS = 0;
    edgeSeen = s && !mPrev;
    mPrev = s;
    expE = edgeSeen && mLocked && (mPos != 0);
    if (edgeSeen) begin
      mLocked = 1'b1;
      cur = 0;
    end else begin
      cur = mPos;
    end
    if (mLocked) begin
      fbit    = (fmtSel == 2'd1) && (cur == 0);
      dp      = (fmtSel == 2'd1) ? cur - 1 : cur;
      slot    = dp / 8;
      b       = dp % 8;
      handled = (fmtSel != 2'd3) || ((slot % 2) == int'(oddSel));
      idx     = (fmtSel == 2'd3) ? slot / 2 : slot;
      if (!fbit && handled && mEn[idx] && mMask[idx][7-b]) begin
        expV = 1'b1;
        expD = d;
        expC = mChan[idx];
        expS = 6'(slot);
      end
      mPos = (cur >= frameLen(fmtSel) - 1) ? 0 : cur + 1;
    end
    if (cfgWe) begin
      mMask[cfgAddr] = cfgMask;
      mChan[cfgAddr] = cfgChan;
      mEn[cfgAddr]   = cfgEn;
    end
    @(posedge rxClk);
    #2;
    total++;
    if (bitValid !== expV || bitData !== expD || bitChan !== expC ||
        bitSlot !== expS || syncErr !== expE) begin
      bad++;
      $display("FAIL %s: actual v=%0b d=%0b ch=%0d sl=%0d err=%0b expected v=%0b d=%0b ch=%0d sl=%0d err=%0b",
               tag, bitValid, bitData, bitChan, bitSlot, syncErr,
               expV, expD, expC, expS, expE);
    end
  endtask

  task automatic cfgWrite(input int a, input logic [7:0] m, input logic [4:0] c,
                          input logic e, input string tag);
    cfgWe = 1'b1; cfgAddr = 5'(a); cfgMask = m; cfgChan = c; cfgEn = e;
    step(1'($urandom % 2), 1'b0, tag);
    cfgWe = 1'b0;
  endtask

  task automatic runFrames(input logic [1:0] f, input logic odd, input int n, input string tag);
    fmtSel = f;
    oddSel = odd;
    for (int fr = 0; fr < n; fr++)
      for (int b = 0; b < frameLen(f); b++)
        step(1'($urandom % 2), b == 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge rxClk);
    total++;
    bad++;
    $display("FAIL watchdog R1: actual=still running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 32; i++) begin
      mMask[i] = 8'hFF; mChan[i] = 5'd0; mEn[i] = 1'b0;
    end
    rstN = 1'b0; rxData = 0; rxSync = 0; fmtSel = 0; oddSel = 0;
    cfgWe = 0; cfgAddr = 0; cfgMask = 0; cfgChan = 0; cfgEn = 0;
    repeat (3) @(posedge rxClk);
    #2;
    total++;
    if (bitValid !== 0 || bitData !== 0 || bitChan !== 0 || bitSlot !== 0 || syncErr !== 0) begin
      bad++;
      $display("FAIL R10 reset: actual v=%0b d=%0b ch=%0d sl=%0d err=%0b expected all 0",
               bitValid, bitData, bitChan, bitSlot, syncErr);
    end
    @(negedge rxClk);
    rstN = 1'b1;

    // R11: fill the table with random entries, some masks empty
    for (int i = 0; i < 32; i++)
      cfgWrite(i, (i % 5 == 0) ? 8'h00 : 8'($urandom), 5'($urandom), ($urandom % 4) != 0, "R11");
    // R1: no strobes before the first sync
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "R1");

    runFrames(2'd0, 1'b0, 1, "R1");
    runFrames(2'd0, 1'b0, 2, "R2");
    runFrames(2'd2, 1'b0, 3, "R3");
    runFrames(2'd1, 1'b0, 3, "R4");
    runFrames(2'd3, 1'b0, 2, "R5");
    runFrames(2'd3, 1'b1, 2, "R5");

    // Directed masks, shared channel, disabled entry
    fmtSel = 2'd0;
    cfgWrite(0, 8'b1000_0001, 5'd7, 1'b1, "R6");
    cfgWrite(1, 8'hFF,        5'd7, 1'b1, "R7");
    cfgWrite(2, 8'hFF,        5'd9, 1'b0, "R8");
    cfgWrite(3, 8'h00,        5'd3, 1'b1, "R6");
    runFrames(2'd0, 1'b0, 1, "R6");
    runFrames(2'd0, 1'b0, 1, "R7");
    runFrames(2'd0, 1'b0, 1, "R8");

    // R11: rewrite entries while the frame keeps running
    for (int i = 0; i < 40; i++)
      cfgWrite(i % 4, 8'($urandom), 5'($urandom), 1'($urandom % 2), "R11");
    runFrames(2'd0, 1'b0, 1, "R11");

    // R9: misplaced sync inside an enabled slot, then a correct boundary
    cfgWrite(0, 8'hFF, 5'd4, 1'b1, "R9");
    cfgWrite(12, 8'hFF, 5'd12, 1'b1, "R9");
    runFrames(2'd0, 1'b0, 1, "R9");
    for (int i = 0; i < 99; i++) step(1'($urandom % 2), 1'b0, "R9");
    step(1'b1, 1'b1, "R9");
    step(1'b0, 1'b1, "R9");
    for (int i = 0; i < 254; i++) step(1'($urandom % 2), 1'b0, "R9");
    step(1'b1, 1'b1, "R9");
    for (int i = 0; i < 20; i++) step(1'($urandom % 2), 1'b0, "R9");

    // R10: idle outputs are checked on every step above; finish with random frames
    runFrames(2'd1, 1'b0, 1, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule